// File: doc/BRIEF.md
# Memory Region Pattern Test Engine

This block is a hardware self-test sequencer for a word-addressed region of 32-bit memory. After a one-cycle `start` pulse it drives a synchronous memory master port through a fixed series of seven data-pattern tests. In each test it fills the region with the pattern and then reads the region back, comparing every word against a value it regenerates from the word's position in the window. It ends with a one-cycle `done` pulse. A `pass` flag reports the result. When a word does not match, the engine records the failing word address, the value it expected and the value it read.

Two coverage modes are available. Slow mode sweeps the whole region once. Normal mode tests only two small windows at each large step through the region: one starting at the step boundary and one ending just below the next boundary. This gives a quick check of memory around every step boundary. The step and window sizes are parameters; their defaults correspond to 1 MB steps and 2 KB windows of 32-bit words. Reads are pipelined, and the memory's read latency is a parameter.

Top module: `mpt_engine`

## Requirements
- R1: The tests run in this order, with kind codes 0 to 6: all zeros 0x00000000, all ones 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, one-hot data 1 << (k mod 32), data equal to k, and data equal to the bitwise inverse of k. Here k is the 32-bit word index within the window.
- R2: Each test first writes every word of the window in ascending address order. Only after the last write does it read every word back, again in ascending order.
- R3: The word index k is 0 at the first word of each tested window, whatever the window's absolute address.
- R4: In slow mode (`slowMode`=1) the seven tests cover the words `baseAddr` to `baseAddr+regionWords-1` once. A `regionWords` of zero causes no memory access and reports a pass.
- R5: In normal mode, let n = regionWords / STEP_WORDS. For each step i from 0 to n-1 in ascending order, the engine runs the full test series on WIN_WORDS words at `baseAddr+i*STEP_WORDS`. It then runs the series on WIN_WORDS words at `baseAddr+i*STEP_WORDS+STEP_WORDS-WIN_WORDS`. When n is 0 there is no memory access and the run reports a pass.
- R6: Every read word is taken from `memRdata` exactly READ_LAT cycles after its read is issued, and it is compared once.
- R7: At the first mismatch the engine stops. It issues no further memory access, runs no remaining test, drives `pass` low, and captures the word address, the expected value and the value read.
- R8: The failure outputs and `pass` hold their values until the next `start`. A `start` clears the failure outputs to zero and sets `pass` to 1.
- R9: `done` is high for exactly one cycle at the end of each run, and no memory access is made in that cycle.
- R10: `memWe` is high only together with `memEn`. After reset `done` and `memEn` are 0, `pass` is 1 and the failure outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run while idle |
| slowMode | input | 1 | 1: whole-region sweep, 0: windows at each step |
| baseAddr | input | ADDR_W | First word address of the region |
| regionWords | input | ADDR_W | Region size in words |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | No mismatch found in the current or last run |
| failAddr | output | ADDR_W | Word address of the first mismatch |
| failExp | output | 32 | Expected value at the first mismatch |
| failAct | output | 32 | Value read at the first mismatch |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid READ_LAT cycles after a read |

## Verification
The memory model in the bench returns read data exactly READ_LAT (here 2) cycles after the read edge, so any misalignment in the engine's return pipeline produces a wrong comparison and is caught. Every access is logged at the clock edge that takes it. The bench checks the whole logged write and read order against the order it expects from R1 to R5. Outputs are sampled on falling edges. `done` is checked on the first falling edge after the final comparison and again one cycle later, where it must be low. After a failure, the bench counts ten further idle cycles to confirm that no access appears and that the captured failure outputs stay put.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  typedef enum logic [2:0] {
    PK_ZERO   = 3'd0,
    PK_ONES   = 3'd1,
    PK_ALT5   = 3'd2,
    PK_ALTA   = 3'd3,
    PK_ONEHOT = 3'd4,
    PK_INDEX  = 3'd5,
    PK_NINDEX = 3'd6
  } patKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setup;
    logic issueWr;
    logic issueRd;
    logic incIdx;
    logic clrIdx;
    logic nextPat;
    logic nextWin;
    logic capFail;
  } ctrlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic idxLast;
    logic patLast;
    logic winLast;
    logic noWork;
    logic mismatch;
    logic pipeBusy;
  } dpStat_t;

  function automatic logic [31:0] patWord(input patKind_t kind, input logic [31:0] idx);
    logic [31:0] w;
    unique case (kind)
      PK_ZERO:   w = 32'h0000_0000;
      PK_ONES:   w = 32'hFFFF_FFFF;
      PK_ALT5:   w = 32'h5555_5555;
      PK_ALTA:   w = 32'hAAAA_AAAA;
      PK_ONEHOT: w = 32'd1 << idx[4:0];
      PK_INDEX:  w = idx;
      PK_NINDEX: w = ~idx;
      default:   w = 32'h0000_0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mpt_ctrl.sv
module mpt_ctrl
  import mpt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  dpStat_t  stat,
  output ctrlStb_t stb,
  output logic     doneP
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_READ, ST_DRAIN, ST_ADV, ST_FIN
  } ctrlState_t;

  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.setup = 1'b1;
          stateD    = stat.noWork ? ST_FIN : ST_FILL;
        end
      end
      ST_FILL: begin
        stb.issueWr = 1'b1;
        if (stat.idxLast) begin
          stb.clrIdx = 1'b1;
          stateD     = ST_READ;
        end else begin
          stb.incIdx = 1'b1;
        end
      end
      ST_READ: begin
        if (stat.mismatch) begin
          stb.capFail = 1'b1;
          stateD      = ST_FIN;
        end else begin
          stb.issueRd = 1'b1;
          if (stat.idxLast) stateD = ST_DRAIN;
          else              stb.incIdx = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (stat.mismatch) begin
          stb.capFail = 1'b1;
          stateD      = ST_FIN;
        end else if (!stat.pipeBusy) begin
          stateD = ST_ADV;
        end
      end
      ST_ADV: begin
        stb.clrIdx = 1'b1;
        if (!stat.patLast) begin
          stb.nextPat = 1'b1;
          stateD      = ST_FILL;
        end else if (stat.winLast) begin
          stateD = ST_FIN;
        end else begin
          stb.nextWin = 1'b1;
          stateD      = ST_FILL;
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign doneP = (stateQ == ST_FIN);

endmodule

// File: rtl/mpt_dpath.sv
module mpt_dpath
  import mpt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned STEP_WORDS = 262144,
  parameter int unsigned WIN_WORDS  = 512,
  parameter int unsigned READ_LAT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              slowMode,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] regionWords,
  input  logic [31:0]       memRdata,
  output dpStat_t           stat,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              passFlag,
  output logic [ADDR_W-1:0] failAddr,
  output logic [31:0]       failExp,
  output logic [31:0]       failAct
);

  localparam int unsigned STEP_SH = $clog2(STEP_WORDS);
  localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(STEP_WORDS);
  localparam logic [ADDR_W-1:0] WIN_M1  = ADDR_W'(WIN_WORDS - 1);
  localparam logic [ADDR_W-1:0] WIN_OFS = ADDR_W'(STEP_WORDS - WIN_WORDS);
  localparam logic [ADDR_W-1:0] ONE_V   = ADDR_W'(1);

  logic              slowQ;
  logic [ADDR_W-1:0] sizeQ;
  logic [ADDR_W-1:0] originQ;
  logic              halfQ;
  logic [ADDR_W-1:0] winCntQ;
  patKind_t          patQ;
  logic [ADDR_W-1:0] idxQ;

  logic [READ_LAT-1:0] vldQ;
  logic [ADDR_W-1:0]   pIdxQ  [READ_LAT];
  logic [ADDR_W-1:0]   pAddrQ [READ_LAT];

  logic [ADDR_W-1:0] winBase;
  logic [ADDR_W-1:0] lenM1;
  logic [ADDR_W-1:0] winCount;
  logic [31:0]       retExp;
  logic              retValid;

  assign winBase  = originQ + (halfQ ? WIN_OFS : '0);
  assign lenM1    = slowQ ? (sizeQ - ONE_V) : WIN_M1;
  assign winCount = sizeQ >> STEP_SH;
  assign retValid = vldQ[READ_LAT-1];
  assign retExp   = patWord(patQ, 32'(pIdxQ[READ_LAT-1]));

  assign stat.idxLast  = (idxQ == lenM1);
  assign stat.patLast  = (patQ == PK_NINDEX);
  assign stat.winLast  = slowQ || (halfQ && (winCntQ == winCount - ONE_V));
  assign stat.noWork   = slowMode ? (regionWords == '0)
                                  : ((regionWords >> STEP_SH) == '0);
  assign stat.mismatch = retValid && (memRdata != retExp);
  assign stat.pipeBusy = |vldQ;

  assign memEn    = stb.issueWr | stb.issueRd;
  assign memWe    = stb.issueWr;
  assign memAddr  = winBase + idxQ;
  assign memWdata = patWord(patQ, 32'(idxQ));

  // run configuration, window walk, pattern and index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowQ   <= 1'b0;
      sizeQ   <= '0;
      originQ <= '0;
      halfQ   <= 1'b0;
      winCntQ <= '0;
      patQ    <= PK_ZERO;
      idxQ    <= '0;
    end else if (stb.setup) begin
      slowQ   <= slowMode;
      sizeQ   <= regionWords;
      originQ <= baseAddr;
      halfQ   <= 1'b0;
      winCntQ <= '0;
      patQ    <= PK_ZERO;
      idxQ    <= '0;
    end else begin
      if (stb.clrIdx)      idxQ <= '0;
      else if (stb.incIdx) idxQ <= idxQ + ONE_V;
      if (stb.nextPat) patQ <= patKind_t'(patQ + 3'd1);
      if (stb.nextWin) begin
        patQ <= PK_ZERO;
        if (halfQ) begin
          halfQ   <= 1'b0;
          originQ <= originQ + STEP_V;
          winCntQ <= winCntQ + ONE_V;
        end else begin
          halfQ <= 1'b1;
        end
      end
    end
  end

  // read return tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ <= '0;
    end else if (stb.setup || stb.capFail) begin
      vldQ <= '0;
    end else begin
      vldQ[0] <= stb.issueRd;
      for (int s = 1; s < READ_LAT; s++) vldQ[s] <= vldQ[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pIdxQ[0]  <= idxQ;
    pAddrQ[0] <= memAddr;
    for (int s = 1; s < READ_LAT; s++) begin
      pIdxQ[s]  <= pIdxQ[s-1];
      pAddrQ[s] <= pAddrQ[s-1];
    end
  end

  // first-failure record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passFlag <= 1'b1;
      failAddr <= '0;
      failExp  <= '0;
      failAct  <= '0;
    end else if (stb.setup) begin
      passFlag <= 1'b1;
      failAddr <= '0;
      failExp  <= '0;
      failAct  <= '0;
    end else if (stb.capFail) begin
      passFlag <= 1'b0;
      failAddr <= pAddrQ[READ_LAT-1];
      failExp  <= retExp;
      failAct  <= memRdata;
    end
  end

endmodule

// File: rtl/mpt_engine.sv
module mpt_engine
  import mpt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned STEP_WORDS = 262144,
  parameter int unsigned WIN_WORDS  = 512,
  parameter int unsigned READ_LAT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              slowMode,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] regionWords,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] failAddr,
  output logic [31:0]       failExp,
  output logic [31:0]       failAct,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);

  ctrlStb_t ctrlStb;
  dpStat_t  dpStat;

  mpt_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (dpStat),
    .stb   (ctrlStb),
    .doneP (done)
  );

  mpt_dpath #(
    .ADDR_W     (ADDR_W),
    .STEP_WORDS (STEP_WORDS),
    .WIN_WORDS  (WIN_WORDS),
    .READ_LAT   (READ_LAT)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (ctrlStb),
    .slowMode    (slowMode),
    .baseAddr    (baseAddr),
    .regionWords (regionWords),
    .memRdata    (memRdata),
    .stat        (dpStat),
    .memEn       (memEn),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .passFlag    (pass),
    .failAddr    (failAddr),
    .failExp     (failExp),
    .failAct     (failAct)
  );

endmodule

// File: rtl/mpt_engine_chk.sv
module mpt_engine_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] failAddr,
  input logic [31:0]       failAct,
  input logic              memEn,
  input logic              memWe
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  quiet_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memEn);

  // R10
  we_with_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  // R7
  halt_after_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pass |-> !memEn);

  // R8
  fail_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(failAddr) |-> ($past(start) || $fell(pass)));

  // R8
  fail_act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(failAct) |-> ($past(start) || $fell(pass)));

endmodule

bind mpt_engine mpt_engine_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/mpt_engine_tb.sv
module mpt_engine_tb_top;

  localparam int AW   = 10;
  localparam int STEP = 64;
  localparam int WIN  = 8;
  localparam int LAT  = 2;
  localparam int LOGN = 4096;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          slowMode = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] regionWords = '0;
  logic          done, pass, memEn, memWe;
  logic [AW-1:0] failAddr, memAddr;
  logic [31:0]   failExp, failAct, memWdata, memRdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mpt_engine #(
    .ADDR_W(AW), .STEP_WORDS(STEP), .WIN_WORDS(WIN), .READ_LAT(LAT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .slowMode(slowMode),
    .baseAddr(baseAddr), .regionWords(regionWords), .done(done), .pass(pass),
    .failAddr(failAddr), .failExp(failExp), .failAct(failAct),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // memory model with fault injection: 0 none, 1 stuck-at-1, 2 stuck-at-0, 3 alias write
  int          fMode = 0;
  int          fAddr = 0;
  int          fSrc  = 0;
  logic [31:0] fMask = '0;
  logic [31:0] mem [1 << AW];
  logic [31:0] rdPipe [LAT];
  logic        opWe   [LOGN];
  int          opAddr [LOGN];
  logic [31:0] opData [LOGN];
  int          opCnt = 0;

  assign memRdata = rdPipe[LAT-1];

  always @(posedge clk) begin
    if (memEn && memWe) begin
      if (fMode == 1 && int'(memAddr) == fAddr)      mem[memAddr] <= memWdata | fMask;
      else if (fMode == 2 && int'(memAddr) == fAddr) mem[memAddr] <= memWdata & ~fMask;
      else                                           mem[memAddr] <= memWdata;
      if (fMode == 3 && int'(memAddr) == fSrc) mem[fAddr] <= memWdata;
    end
    rdPipe[0] <= mem[memAddr];
    for (int k = 1; k < LAT; k++) rdPipe[k] <= rdPipe[k-1];
    if (memEn && opCnt < LOGN) begin
      opWe[opCnt]   <= memWe;
      opAddr[opCnt] <= int'(memAddr);
      opData[opCnt] <= memWdata;
      opCnt         <= opCnt + 1;
    end
  end

  function automatic logic [31:0] expPat(input int t, input int i);
    case (t)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h5555_5555;
      3: return 32'hAAAA_AAAA;
      4: return 32'd1 << (i % 32);
      5: return 32'(i);
      default: return ~32'(i);
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int mark = 0;

  task automatic runEngine(input logic slow, input int base, input int size);
    int cyc;
    @(negedge clk);
    slowMode    = slow;
    baseAddr    = AW'(base);
    regionWords = AW'(size);
    start       = 1'b1;
    mark        = opCnt;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R9 done seen", 32'(done), 32'd1);
    chk(!memEn, "R9 no access in done cycle", 32'(memEn), 32'd0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 32'(done), 32'd0);
  endtask

  // checks one window's seven tests from op index p; returns next op index
  task automatic checkWindow(input int p, input int base, input int len, input string req, output int nxt);
    int bad = 0;
    int q = p;
    int firstAct = 0;
    int firstExp = 0;
    for (int t = 0; t < 7; t++) begin
      for (int i = 0; i < len; i++) begin
        if (!(opWe[q] == 1'b1 && opAddr[q] == base + i && opData[q] == expPat(t, i))) begin
          if (bad == 0) begin firstAct = int'(opData[q]); firstExp = int'(expPat(t, i)); end
          bad++;
        end
        q++;
      end
      for (int i = 0; i < len; i++) begin
        if (!(opWe[q] == 1'b0 && opAddr[q] == base + i)) begin
          if (bad == 0) begin firstAct = opAddr[q]; firstExp = base + i; end
          bad++;
        end
        q++;
      end
    end
    chk(bad == 0, req, 32'(firstAct), 32'(firstExp));
    nxt = q;
  endtask

  task automatic testReset();
    chk(!done, "R10 reset done", 32'(done), 32'd0);
    chk(!memEn, "R10 reset memEn", 32'(memEn), 32'd0);
    chk(pass, "R10 reset pass", 32'(pass), 32'd1);
    chk(failAddr == '0 && failExp == '0, "R10 reset fail outputs", 32'(failAddr), 32'd0);
  endtask

  task automatic testSlowPass();
    int p;
    fMode = 0;
    runEngine(1'b1, 100, 20);
    chk(pass, "R4 slow pass", 32'(pass), 32'd1);
    chk(opCnt - mark == 280, "R4 slow op count", 32'(opCnt - mark), 32'd280);
    checkWindow(mark, 100, 20, "R1 R2 slow order and data", p);
    chk(failAddr == '0 && failAct == '0, "R8 cleared after pass", failAct, 32'd0);
  endtask

  task automatic testNormalPass();
    int p;
    fMode = 0;
    runEngine(1'b0, 64, 130);
    chk(pass, "R5 normal pass", 32'(pass), 32'd1);
    chk(opCnt - mark == 448, "R5 normal op count", 32'(opCnt - mark), 32'd448);
    p = mark;
    checkWindow(p, 64, WIN, "R5 R3 window 0 low", p);
    checkWindow(p, 64 + STEP - WIN, WIN, "R5 R3 window 0 high", p);
    checkWindow(p, 128, WIN, "R5 R3 window 1 low", p);
    checkWindow(p, 128 + STEP - WIN, WIN, "R5 R3 window 1 high", p);
  endtask

  task automatic testNoWork();
    runEngine(1'b0, 0, STEP - 1);
    chk(pass && opCnt == mark, "R5 small region no access", 32'(opCnt - mark), 32'd0);
    runEngine(1'b1, 5, 0);
    chk(pass && opCnt == mark, "R4 zero size no access", 32'(opCnt - mark), 32'd0);
  endtask

  task automatic testStuckOne();
    int bad = 0;
    int reads = 0;
    int cnt;
    logic [AW-1:0] fa;
    fMode = 1; fAddr = 5; fMask = 32'h1;
    runEngine(1'b1, 0, 40);
    chk(!pass, "R7 stuck-1 fails", 32'(pass), 32'd0);
    chk(failAddr == AW'(5), "R7 fail address", 32'(failAddr), 32'd5);
    chk(failExp == 32'h0, "R7 fail expected", failExp, 32'h0);
    chk(failAct == 32'h1, "R7 fail actual", failAct, 32'h1);
    for (int q = mark + 40; q < opCnt; q++) begin
      if (opWe[q]) bad++;
      else reads++;
    end
    chk(bad == 0 && reads >= 6 && reads < 40, "R7 stops after mismatch", 32'(reads), 32'd6);
    cnt = opCnt;
    fa  = failAddr;
    repeat (10) @(negedge clk);
    chk(opCnt == cnt, "R8 no access while held", 32'(opCnt - cnt), 32'd0);
    chk(failAddr == fa && !pass && failAct == 32'h1, "R8 failure held", failAct, 32'h1);
    fMode = 0;
  endtask

  task automatic testStuckZero();
    fMode = 2; fAddr = 9; fMask = 32'h8;
    runEngine(1'b1, 0, 16);
    chk(!pass && failAddr == AW'(9), "R1 second test is ones", 32'(failAddr), 32'd9);
    chk(failExp == 32'hFFFF_FFFF && failAct == 32'hFFFF_FFF7, "R1 ones mismatch values", failAct, 32'hFFFF_FFF7);
    fMode = 0;
  endtask

  task automatic testAlias();
    fMode = 3; fAddr = 4; fSrc = 20;
    runEngine(1'b1, 0, 32);
    chk(!pass && failAddr == AW'(4), "R1 one-hot alias address", 32'(failAddr), 32'd4);
    chk(failExp == 32'h0000_0010, "R1 one-hot expected", failExp, 32'h10);
    chk(failAct == 32'h0010_0000, "R6 one-hot value read", failAct, 32'h0010_0000);
    fMode = 0;
  endtask

  task automatic testRestart();
    runEngine(1'b1, 200, 10);
    chk(pass, "R8 restart sets pass", 32'(pass), 32'd1);
    chk(failAddr == '0 && failExp == '0 && failAct == '0, "R8 restart clears fail outputs", failAct, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSlowPass();
    testNormalPass();
    testNoWork();
    testStuckOne();
    testStuckZero();
    testAlias();
    testRestart();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule